// File: doc/BRIEF.md
# Fetch Next-PC Predictor

This block sits beside the instruction fetch stage and guesses the address of the next fetch in the same cycle the current fetch address is presented. Two tables do the work. A direct-mapped table of 2-bit saturating counters guesses whether the instruction at the fetch address is a taken branch. A tagged target buffer holds the address that branch jumped to most recently. The buffer only matters when the counter guesses taken. In every other case, and when the buffer has no matching entry, the guess is the sequential address, fetch PC plus 4.

Later in the pipeline the real outcome of a branch becomes known. That result comes back on a single update port carrying the branch PC, whether it was taken, and where it went. The update moves the matching counter one step toward the outcome. A taken outcome also records the target in the buffer. Both table lookups are combinational reads of registered state, and writes take effect at the clock edge. A prediction made in the same cycle as an update to the same entry therefore sees the old contents.

Top module: `nextpc_predictor`

## Requirements
- R1: On an update, the counter selected by the update PC moves up by one if the branch was taken and down by one if not, and stays at 0 or at 3 rather than wrapping.
- R2: The direction guess on `pred_taken` is 0 for counter values 0 and 1 and is 1 for counter values 2 and 3.
- R3: The counter index is PC bits [2 +: log2(DIR_ENTRIES)]. Two PCs that differ only above those bits share a counter, and PCs that differ inside those bits use separate counters.
- R4: When `pred_taken` is 0, `pred_next_pc` equals `fetch_pc + 4`, whatever the buffer holds.
- R5: `pred_hit` is 1 when the buffer entry at index PC bits [2 +: log2(BTB_ENTRIES)] is valid and its stored tag equals the PC bits above that index. When `pred_taken` and `pred_hit` are both 1, `pred_next_pc` is the stored target.
- R6: When `pred_taken` is 1 and `pred_hit` is 0, either because the entry is invalid or because its tag differs, `pred_next_pc` equals `fetch_pc + 4`.
- R7: A taken update writes the target and tag into its buffer entry and marks the entry valid. A later taken update to the same entry replaces the earlier target.
- R8: A not-taken update does not change the target buffer. An entry that hit before still hits afterwards with the same target.
- R9: After reset every counter holds 1, so every PC is predicted not-taken, and every buffer entry is invalid.
- R10: A prediction in the same cycle as an update to the same entry uses the contents from before the update. The new contents are visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; table writes happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of counters and valid bits |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_next_pc | output | PC_W | Predicted address of the next fetch |
| pred_taken | output | 1 | Direction guess of the counter at fetch_pc |
| pred_hit | output | 1 | Target buffer holds a valid matching entry for fetch_pc |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome of the resolved branch |
| upd_target | input | PC_W | Actual target of the resolved branch |

## Verification
The bench runs on a small configuration with 8 counters and 4 buffer entries. It first sweeps the fetch address over a range after reset to confirm the not-taken, no-hit state everywhere. Next it walks one counter from the floor to the ceiling and back with repeated same-direction updates; this separates correct saturation from wrapping and shows the point at which the guess flips. Directed pairs of addresses then distinguish these cases from one another: sharing a counter but not a tag, sharing neither, a hit, an overwritten target, and an entry kept through not-taken updates. An update and a fetch on the same entry in one cycle tell the old contents apart from the new. A long pseudo-random mix of fetches and updates, scored against an arithmetic model of both tables, covers the interleavings the directed cases do not reach.

// File: rtl/npp_pkg.sv
package npp_pkg;

   // Counter values; the upper bit is the taken guess
   typedef enum logic [1:0] {
      CTR_NT_STRONG = 2'b00,
      CTR_NT_WEAK   = 2'b01,
      CTR_TK_WEAK   = 2'b10,
      CTR_TK_STRONG = 2'b11
   } ctr_e;

   localparam ctr_e CTR_RESET = CTR_NT_WEAK;

   // Byte distance between sequential instructions
   localparam int unsigned INSTR_BYTES = 4;
   localparam int unsigned INSTR_LSB   = 2;

   function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
      ctr_e nxt;
      if (taken)
         nxt = (cur == CTR_TK_STRONG) ? CTR_TK_STRONG : ctr_e'(cur + 2'd1);
      else
         nxt = (cur == CTR_NT_STRONG) ? CTR_NT_STRONG : ctr_e'(cur - 2'd1);
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input ctr_e cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/npp_dir_table.sv
module npp_dir_table
   import npp_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_taken,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic            wr_taken
);

   localparam int unsigned IDX_BITS = $clog2(ENTRIES);
   localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;

   ctr_e             ctr_q [ENTRIES];
   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic             unused_rd_bits;
   logic             unused_wr_bits;

   generate
      if (IDX_BITS == 0) begin : g_single
         assign rd_idx = '0;
         assign wr_idx = '0;
      end else begin : g_indexed
         assign rd_idx = rd_pc[INSTR_LSB +: IDX_BITS];
         assign wr_idx = wr_pc[INSTR_LSB +: IDX_BITS];
      end
   endgenerate

   assign unused_rd_bits = ^rd_pc;
   assign unused_wr_bits = ^wr_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= CTR_RESET;
      end else if (wr_en) begin
         ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
      end
   end

   assign rd_taken = ctr_says_taken(ctr_q[rd_idx]);

endmodule

// File: rtl/npp_tgt_buffer.sv
module npp_tgt_buffer
   import npp_pkg::*;
#(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned ENTRIES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] rd_pc,
   output logic            rd_hit,
   output logic [PC_W-1:0] rd_target,
   input  logic            wr_en,
   input  logic [PC_W-1:0] wr_pc,
   input  logic [PC_W-1:0] wr_target
);

   localparam int unsigned IDX_BITS = $clog2(ENTRIES);
   localparam int unsigned IDX_W    = (IDX_BITS > 0) ? IDX_BITS : 1;
   localparam int unsigned TAG_LSB  = INSTR_LSB + IDX_BITS;
   localparam int unsigned TAG_W    = PC_W - TAG_LSB;

   logic             valid_q  [ENTRIES];
   logic [TAG_W-1:0] tag_q    [ENTRIES];
   logic [PC_W-1:0]  target_q [ENTRIES];

   logic [IDX_W-1:0] rd_idx;
   logic [IDX_W-1:0] wr_idx;
   logic [TAG_W-1:0] rd_tag;
   logic [TAG_W-1:0] wr_tag;
   logic             unused_rd_lsb;
   logic             unused_wr_lsb;

   generate
      if (IDX_BITS == 0) begin : g_single
         assign rd_idx = '0;
         assign wr_idx = '0;
      end else begin : g_indexed
         assign rd_idx = rd_pc[INSTR_LSB +: IDX_BITS];
         assign wr_idx = wr_pc[INSTR_LSB +: IDX_BITS];
      end
   endgenerate

   assign rd_tag        = rd_pc[PC_W-1:TAG_LSB];
   assign wr_tag        = wr_pc[PC_W-1:TAG_LSB];
   assign unused_rd_lsb = ^rd_pc[INSTR_LSB-1:0];
   assign unused_wr_lsb = ^wr_pc[INSTR_LSB-1:0];

   // Only the valid bits need a reset value
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) valid_q[i] <= 1'b0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]    <= wr_tag;
         target_q[wr_idx] <= wr_target;
      end
   end

   assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_target = target_q[rd_idx];

endmodule

// File: rtl/npp_select.sv
module npp_select
   import npp_pkg::*;
#(
   parameter int unsigned PC_W = 32
) (
   input  logic [PC_W-1:0] pc,
   input  logic            dir_taken,
   input  logic            tgt_hit,
   input  logic [PC_W-1:0] tgt_addr,
   output logic [PC_W-1:0] next_pc
);

   logic [PC_W-1:0] seq_pc;

   assign seq_pc = pc + PC_W'(INSTR_BYTES);

   always_comb begin
      if (dir_taken && tgt_hit) next_pc = tgt_addr;
      else                      next_pc = seq_pc;
   end

endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
   import npp_pkg::*;
#(
   parameter int unsigned PC_W        = 32,
   parameter int unsigned DIR_ENTRIES = 64,
   parameter int unsigned BTB_ENTRIES = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic [PC_W-1:0] pred_next_pc,
   output logic            pred_taken,
   output logic            pred_hit,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target
);

   localparam int unsigned DIR_IDX_BITS = $clog2(DIR_ENTRIES);
   localparam int unsigned BTB_IDX_BITS = $clog2(BTB_ENTRIES);

   initial begin
      if ((DIR_ENTRIES & (DIR_ENTRIES - 1)) != 0)
         $fatal(1, "DIR_ENTRIES must be a power of two");
      if ((BTB_ENTRIES & (BTB_ENTRIES - 1)) != 0)
         $fatal(1, "BTB_ENTRIES must be a power of two");
      if (PC_W <= INSTR_LSB + BTB_IDX_BITS)
         $fatal(1, "PC_W leaves no tag bits");
      if (PC_W < INSTR_LSB + DIR_IDX_BITS)
         $fatal(1, "PC_W too narrow for the counter index");
   end

   logic            dir_taken;
   logic            btb_hit;
   logic [PC_W-1:0] btb_target;

   npp_dir_table #(
      .PC_W    (PC_W),
      .ENTRIES (DIR_ENTRIES)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_pc    (fetch_pc),
      .rd_taken (dir_taken),
      .wr_en    (upd_valid),
      .wr_pc    (upd_pc),
      .wr_taken (upd_taken)
   );

   npp_tgt_buffer #(
      .PC_W    (PC_W),
      .ENTRIES (BTB_ENTRIES)
   ) u_btb (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_pc     (fetch_pc),
      .rd_hit    (btb_hit),
      .rd_target (btb_target),
      .wr_en     (upd_valid && upd_taken),
      .wr_pc     (upd_pc),
      .wr_target (upd_target)
   );

   npp_select #(
      .PC_W (PC_W)
   ) u_sel (
      .pc        (fetch_pc),
      .dir_taken (dir_taken),
      .tgt_hit   (btb_hit),
      .tgt_addr  (btb_target),
      .next_pc   (pred_next_pc)
   );

   assign pred_taken = dir_taken;
   assign pred_hit   = btb_hit;

endmodule

// File: rtl/npp_checker.sv
module npp_checker #(
   parameter int unsigned PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            pred_taken,
   input logic            pred_hit,
   input logic            upd_valid,
   input logic [PC_W-1:0] upd_pc,
   input logic            upd_taken,
   input logic [PC_W-1:0] upd_target
);

   AST_NT_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> pred_next_pc == fetch_pc + PC_W'(4)); // R4

   AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_taken && !pred_hit) |-> pred_next_pc == fetch_pc + PC_W'(4)); // R6

   AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken) |=>
         (fetch_pc != $past(upd_pc)) ||
         (pred_hit && (!pred_taken || pred_next_pc == $past(upd_target)))); // R7

   AST_NT_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && pred_hit && fetch_pc == upd_pc) |=>
         (fetch_pc != $past(fetch_pc)) || pred_hit); // R8

   AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && upd_taken && !pred_hit && fetch_pc == upd_pc) |->
         pred_next_pc == fetch_pc + PC_W'(4)); // R10

endmodule

bind nextpc_predictor npp_checker #(.PC_W(PC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_pc     (fetch_pc),
   .pred_next_pc (pred_next_pc),
   .pred_taken   (pred_taken),
   .pred_hit     (pred_hit),
   .upd_valid    (upd_valid),
   .upd_pc       (upd_pc),
   .upd_taken    (upd_taken),
   .upd_target   (upd_target)
);

// File: tb/nextpc_predictor_tb.sv
module nextpc_predictor_tb;

   localparam int PC_W = 16;
   localparam int DIRN = 8;
   localparam int BTBN = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic [PC_W-1:0] pred_next_pc;
   logic            pred_taken;
   logic            pred_hit;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;
   logic [PC_W-1:0] upd_target = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Model of both tables, derived from the requirements
   int              m_ctr [DIRN];
   bit              m_val [BTBN];
   int              m_tag [BTBN];
   logic [PC_W-1:0] m_tgt [BTBN];

   always #2 clk = ~clk;

   nextpc_predictor #(
      .PC_W        (PC_W),
      .DIR_ENTRIES (DIRN),
      .BTB_ENTRIES (BTBN)
   ) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_pc     (fetch_pc),
      .pred_next_pc (pred_next_pc),
      .pred_taken   (pred_taken),
      .pred_hit     (pred_hit),
      .upd_valid    (upd_valid),
      .upd_pc       (upd_pc),
      .upd_taken    (upd_taken),
      .upd_target   (upd_target)
   );

   function automatic int didx(input logic [PC_W-1:0] pc);
      return int'(pc >> 2) % DIRN;
   endfunction
   function automatic int bidx(input logic [PC_W-1:0] pc);
      return int'(pc >> 2) % BTBN;
   endfunction
   function automatic int btag(input logic [PC_W-1:0] pc);
      return int'(pc >> 4);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive one cycle; check outputs against the pre-update model
   task automatic cyc(input bit uv, input logic [PC_W-1:0] upc, input bit ut,
                      input logic [PC_W-1:0] utg, input logic [PC_W-1:0] fpc,
                      input string req);
      bit e_tk, e_hit;
      logic [PC_W-1:0] e_nxt;
      upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utg;
      fetch_pc = fpc;
      #1;
      e_tk  = m_ctr[didx(fpc)] >= 2;
      e_hit = m_val[bidx(fpc)] && m_tag[bidx(fpc)] == btag(fpc);
      e_nxt = (e_tk && e_hit) ? m_tgt[bidx(fpc)] : fpc + 16'd4;
      chk({req, " taken"}, int'(pred_taken), int'(e_tk));
      chk({req, " hit"},   int'(pred_hit),   int'(e_hit));
      chk({req, " next"},  int'(pred_next_pc), int'(e_nxt));
      @(posedge clk);
      if (uv) begin
         if (ut) begin
            if (m_ctr[didx(upc)] < 3) m_ctr[didx(upc)]++;
            m_val[bidx(upc)] = 1'b1;
            m_tag[bidx(upc)] = btag(upc);
            m_tgt[bidx(upc)] = utg;
         end else if (m_ctr[didx(upc)] > 0) begin
            m_ctr[didx(upc)]--;
         end
      end
      @(negedge clk);
   endtask

   task automatic summary;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
   end

   initial begin
      logic [15:0] lfsr;
      string tag;
      for (int i = 0; i < DIRN; i++) m_ctr[i] = 1;
      for (int i = 0; i < BTBN; i++) begin m_val[i] = 0; m_tag[i] = 0; m_tgt[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R9: reset state, sweep fetch addresses
      for (int pc = 0; pc < 256; pc += 4) cyc(0, 0, 0, 0, 16'(pc), "R9");

      // R1 and R2: walk one counter to the ceiling and back to the floor
      for (int k = 0; k < 4; k++) begin
         cyc(1, 16'h0040, 1, 16'h0400, 16'h0040, "R1");
         chk("R2 count up", m_ctr[didx(16'h0040)], (k + 2 > 3) ? 3 : k + 2);
      end
      for (int k = 0; k < 5; k++) begin
         cyc(1, 16'h0040, 0, 0, 16'h0040, "R1");
         chk("R1 count down", m_ctr[didx(16'h0040)], (2 - k < 0) ? 0 : 2 - k);
      end
      cyc(0, 0, 0, 0, 16'h0040, "R2");

      // R3 and R6: aliasing counter, tag mismatch, separate counter
      cyc(1, 16'h0044, 1, 16'h1230, 16'h0000, "R3");
      cyc(1, 16'h0044, 1, 16'h1230, 16'h0000, "R3");
      cyc(0, 0, 0, 0, 16'h0064, "R6");   // same counter and slot, other tag
      chk("R6 taken alias", int'(pred_taken), 1);
      cyc(0, 0, 0, 0, 16'h0054, "R3");   // different counter
      chk("R3 separate", int'(pred_taken), 0);

      // R5: hit supplies the target
      cyc(0, 0, 0, 0, 16'h0044, "R5");
      chk("R5 target", int'(pred_next_pc), 16'h1234 - 16'h4);

      // R7: later taken update replaces the target
      cyc(1, 16'h0044, 1, 16'h2000, 16'h0000, "R7");
      cyc(0, 0, 0, 0, 16'h0044, "R7");
      chk("R7 new target", int'(pred_next_pc), 16'h2000);

      // R8: not-taken updates leave the buffer entry
      cyc(1, 16'h0044, 0, 16'hFFFC, 16'h0044, "R8");
      cyc(1, 16'h0044, 0, 16'hFFFC, 16'h0044, "R8");
      cyc(0, 0, 0, 0, 16'h0044, "R8");
      chk("R8 still hit", int'(pred_hit), 1);
      cyc(1, 16'h0044, 1, 16'h2000, 16'h0000, "R8");
      cyc(0, 0, 0, 0, 16'h0044, "R8");
      chk("R8 target kept", int'(pred_next_pc), 16'h2000);

      // R10: same-cycle update and fetch on a fresh entry
      cyc(1, 16'h0308, 1, 16'h0ABC, 16'h0308, "R10");
      cyc(0, 0, 0, 0, 16'h0308, "R10");
      chk("R10 after", int'(pred_next_pc), 16'h0ABC);

      // R4/R5/R6 under a pseudo-random mix
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         logic [PC_W-1:0] fpc, upc, utg;
         bit uv, ut;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         fpc = {6'd0, lfsr[7:0], 2'b00};
         uv  = lfsr[8];
         ut  = lfsr[9] | lfsr[11];
         upc = lfsr[10] ? fpc : {6'd0, lfsr[15:8], 2'b00};
         utg = {lfsr[3:0], lfsr[15:6], 2'b00};
         if (m_ctr[didx(fpc)] < 2) tag = "R4";
         else if (m_val[bidx(fpc)] && m_tag[bidx(fpc)] == btag(fpc)) tag = "R5";
         else tag = "R6";
         cyc(uv, upc, ut, utg, fpc, tag);
      end

      summary();
   end

endmodule